// File: doc/BRIEF.md
# Auto-Rotating Byte Field Extractor

This block turns a stream of 32-bit words, each holding four packed one-byte characters, into one character per read for a compute datapath. Words enter a word-organised buffer sized for 128 characters, so that a datapath can keep consuming while the next fetch is still under way. A load strobe moves the oldest buffered word into a data register. Each field-read strobe returns the field that a control register selects, zero-extended to 32 bits. The same strobe then rotates the data register right by the field width. With the default 8-bit setting, four reads in a row walk through the four characters, lowest byte first, and need no shift step in between.

The input side is a valid/ready stream. A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls while the buffer holds its full count of words. While `in_ready` is low, the producer must hold the word and keep `in_valid` asserted. On the output side the datapath is the master, so there is no back-pressure there: every `fld_rd` strobe produces exactly one `fld_valid` pulse one cycle later. Loads and control writes are plain strobes. A load while the buffer is empty is dropped and reported on `load_underflow`.

Top module: `byte_field_unpacker`

## Requirements
- R1: After reset, the data register is zero, the control register selects position 0 and width 8, `fifo_empty` is 1, `in_ready` is 1, and `fld_valid` and `load_underflow` are 0.
- R2: A word is accepted on an edge where `in_valid` and `in_ready` are both high. The buffer holds 32 words (128 characters). `in_ready` is low exactly while 32 words are stored, and a word offered then is not stored.
- R3: `load_req` while the buffer is non-empty moves the oldest stored word into the data register, in arrival order.
- R4: `load_req` while the buffer is empty leaves the data register unchanged, and `load_underflow` is high in the following cycle only.
- R5: In the cycle after a `fld_rd` strobe, `fld_valid` is 1 and `fld_data` equals `(D >> pos) & ((1<<w)-1)`, where D is the data register before the strobe. All bits at and above w are zero. `fld_valid` is 0 in every cycle that does not follow a strobe.
- R6: A `fld_rd` strobe without a load rotates the data register right by w bits. With position 0 and width 8, four reads return bits [7:0], [15:8], [23:16] and [31:24] in that order.
- R7: After four width-8 reads, the data register is back in its original order, so a fifth read returns bits [7:0] again.
- R8: When `load_req` (buffer non-empty) and `fld_rd` are in the same cycle, the field comes from the old data register and the data register takes the new word without rotation.
- R9: `ctl_we` writes `ctl_pos` (5 bits) and `ctl_len` (6 bits). A `ctl_len` of 0 or above 32 means width 32. A new setting applies from the next cycle's strobes onward. A read in the same cycle as the write uses the old setting.
- R10: `fifo_empty` is 1 exactly while no word is stored. A push into an empty buffer in the same cycle as a load does not satisfy that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | 32 | Input word, four packed characters |
| load_req | input | 1 | Pop oldest word into the data register |
| load_underflow | output | 1 | Previous cycle's load found the buffer empty |
| fifo_empty | output | 1 | No word stored |
| ctl_we | input | 1 | Control register write strobe |
| ctl_pos | input | 5 | Field position (LSB index) to write |
| ctl_len | input | 6 | Field width to write (0 or >32 means 32) |
| fld_rd | input | 1 | Field-read strobe, rotates after extraction |
| fld_valid | output | 1 | Field output valid, one cycle after a strobe |
| fld_data | output | 32 | Extracted field, zero-extended |

## Verification
`fld_data`, `fld_valid` and `load_underflow` are registered. They are due one edge after the strobe that caused them, and the bench samples them 1 ns after that edge. `in_ready` and `fifo_empty` follow the stored word count with no delay beyond the edge that changed it, so they are compared at the same sample point against the bench's model queue. A load or control write therefore shows its effect in the field returned by a read issued on any later cycle. The bench applies every input at the falling edge and updates its model once per rising edge, so each expected value is fixed before the edge it is compared after.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int LEN_W  = $clog2(WORD_W) + 1;

  typedef struct packed {
    logic [POS_W-1:0] pos;
    logic [LEN_W-1:0] width;
  } field_sel_t;
endpackage

// File: rtl/bfu_word_fifo.sv
module bfu_word_fifo #(
  parameter int WORD_W  = 32,
  parameter int DEPTH_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop_req,
  output logic              pop_ok,
  output logic [WORD_W-1:0] head_data,
  output logic              empty,
  output logic              underflow
);
  localparam int PTR_W = (DEPTH_W > 1) ? $clog2(DEPTH_W) : 1;
  localparam int CNT_W = $clog2(DEPTH_W + 1);

  logic [WORD_W-1:0] mem [DEPTH_W];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              push_fire;

  assign empty      = (count == '0);
  assign push_ready = (count != CNT_W'(DEPTH_W));
  assign push_fire  = push_valid && push_ready;
  assign pop_ok     = pop_req && !empty;
  assign head_data  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH_W - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= pop_req && empty;
      if (push_fire) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)    rd_ptr <= next_ptr(rd_ptr);
      case ({push_fire, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH_W));
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop_ok) |=> !push_ready);
  // R4
  underflow_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> underflow);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_valid) |=> empty);
endmodule

// File: rtl/bfu_field_ctl.sv
module bfu_field_ctl
  import bfu_pkg::*;
#(
  parameter int DEF_WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [POS_W-1:0] wr_pos,
  input  logic [LEN_W-1:0] wr_len,
  output field_sel_t       sel
);
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (wr_len == '0 || wr_len > LEN_W'(WORD_W)) ? LEN_W'(WORD_W) : wr_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel.pos   <= '0;
      sel.width <= LEN_W'(DEF_WIDTH);
    end else if (we) begin
      sel.pos   <= wr_pos;
      sel.width <= eff_len;
    end
  end

  // R9
  width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.width != '0 && sel.width <= LEN_W'(WORD_W));
  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(sel));
endmodule

// File: rtl/bfu_field_reg.sv
module bfu_field_reg
  import bfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              rd,
  input  field_sel_t        sel,
  output logic              fld_valid,
  output logic [WORD_W-1:0] fld_data
);
  logic [WORD_W-1:0]   data_q;
  logic [WORD_W-1:0]   extracted;
  logic [WORD_W-1:0]   rotated;
  logic [WORD_W-1:0]   mask;
  logic [2*WORD_W-1:0] doubled;

  assign mask      = ~({WORD_W{1'b1}} << sel.width);
  assign extracted = (data_q >> sel.pos) & mask;
  assign doubled   = {data_q, data_q} >> sel.width;
  assign rotated   = doubled[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      fld_valid <= 1'b0;
      fld_data  <= '0;
    end else begin
      fld_valid <= rd;
      if (rd) fld_data <= extracted;
      if (load)    data_q <= load_data;
      else if (rd) data_q <= rotated;
    end
  end

  // R6
  rotate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !load) |=> $countones(data_q) == $countones($past(data_q)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !load) |=> $stable(data_q));
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !fld_valid);
  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> data_q == $past(load_data));
endmodule

// File: rtl/byte_field_unpacker.sv
module byte_field_unpacker
  import bfu_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int FIFO_CHARS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              load_req,
  output logic              load_underflow,
  output logic              fifo_empty,
  input  logic              ctl_we,
  input  logic [POS_W-1:0]  ctl_pos,
  input  logic [LEN_W-1:0]  ctl_len,
  input  logic              fld_rd,
  output logic              fld_valid,
  output logic [WORD_W-1:0] fld_data
);
  localparam int CHARS_PER_WORD = WORD_W / CHAR_W;
  localparam int DEPTH_W        = FIFO_CHARS / CHARS_PER_WORD;

  logic              pop_ok;
  logic [WORD_W-1:0] head_data;
  field_sel_t        sel;

  bfu_word_fifo #(.WORD_W(WORD_W), .DEPTH_W(DEPTH_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_ready(in_ready), .push_data(in_data),
    .pop_req(load_req), .pop_ok(pop_ok), .head_data(head_data),
    .empty(fifo_empty), .underflow(load_underflow)
  );

  bfu_field_ctl #(.DEF_WIDTH(CHAR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we),
    .wr_pos(ctl_pos), .wr_len(ctl_len), .sel(sel)
  );

  bfu_field_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load(pop_ok), .load_data(head_data),
    .rd(fld_rd), .sel(sel), .fld_valid(fld_valid), .fld_data(fld_data)
  );

  // R3
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> !fifo_empty);
  // R1
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_underflow |-> $past(load_req));
endmodule

// File: tb/sim_byte_field_unpacker.sv
module sim_byte_field_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        load_req = 1'b0;
  logic        load_underflow;
  logic        fifo_empty;
  logic        ctl_we = 1'b0;
  logic [4:0]  ctl_pos = '0;
  logic [5:0]  ctl_len = '0;
  logic        fld_rd = 1'b0;
  logic        fld_valid;
  logic [31:0] fld_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [31:0] q[$];
  logic [31:0] m_d = '0;
  int          m_pos = 0;
  int          m_w = 8;
  logic [31:0] last_fld;

  always #2 clk = ~clk;

  byte_field_unpacker u0 (.*);

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rot(input logic [31:0] d, input int n);
    logic [31:0] r = d;
    for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  function automatic logic [31:0] field(input logic [31:0] d, input int p, input int w);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++)
      if (p + i < 32) r[i] = d[p + i];
    return r;
  endfunction

  function automatic int eff(input int len);
    return (len == 0 || len > 32) ? 32 : len;
  endfunction

  task automatic step(input bit iv, input logic [31:0] id, input bit ld, input bit rd,
                      input bit cwe, input int cpos, input int clen, input string rtag);
    bit acc, pop, uf;
    logic [31:0] exp_f;
    @(negedge clk);
    in_valid = iv; in_data = id; load_req = ld; fld_rd = rd;
    ctl_we = cwe; ctl_pos = cpos[4:0]; ctl_len = clen[5:0];
    #0.5;
    check(in_ready == (q.size() < 32), "R2", {31'd0, in_ready}, {31'd0, q.size() < 32});
    acc = iv && q.size() < 32;
    pop = ld && q.size() > 0;
    uf = ld && q.size() == 0;
    exp_f = field(m_d, m_pos, m_w);
    if (pop) m_d = q.pop_front();
    else if (rd) m_d = rot(m_d, m_w);
    if (acc) q.push_back(id);
    if (cwe) begin m_pos = cpos; m_w = eff(clen); end
    @(posedge clk);
    #1;
    check(fld_valid == rd, "R5", {31'd0, fld_valid}, {31'd0, rd});
    if (rd) begin
      check(fld_data == exp_f, rtag, fld_data, exp_f);
      last_fld = fld_data;
    end
    check(load_underflow == uf, "R4", {31'd0, load_underflow}, {31'd0, uf});
    check(fifo_empty == (q.size() == 0), "R10", {31'd0, fifo_empty}, {31'd0, q.size() == 0});
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, 0, 0, "R5");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R1 reset state
    check(fifo_empty == 1'b1, "R1", {31'd0, fifo_empty}, 32'd1);
    check(in_ready == 1'b1, "R1", {31'd0, in_ready}, 32'd1);
    check(fld_valid == 1'b0, "R1", {31'd0, fld_valid}, 32'd0);
    check(load_underflow == 1'b0, "R1", {31'd0, load_underflow}, 32'd0);
    // R4 load while empty: data stays zero
    step(0, '0, 1, 0, 0, 0, 0, "R4");
    step(0, '0, 0, 1, 0, 0, 0, "R1");
    check(last_fld == 32'd0, "R4", last_fld, 32'd0);
    // R10 push and load same cycle into empty buffer: load misses
    step(1, 32'h4154_4743, 1, 0, 0, 0, 0, "R10");
    step(0, '0, 1, 0, 0, 0, 0, "R3");
    // R6 four reads lowest byte first, R7 fifth wraps
    step(0, '0, 0, 1, 0, 0, 0, "R6"); check(last_fld == 32'h43, "R6", last_fld, 32'h43);
    step(0, '0, 0, 1, 0, 0, 0, "R6"); check(last_fld == 32'h47, "R6", last_fld, 32'h47);
    step(0, '0, 0, 1, 0, 0, 0, "R6"); check(last_fld == 32'h54, "R6", last_fld, 32'h54);
    step(0, '0, 0, 1, 0, 0, 0, "R6"); check(last_fld == 32'h41, "R6", last_fld, 32'h41);
    step(0, '0, 0, 1, 0, 0, 0, "R7"); check(last_fld == 32'h43, "R7", last_fld, 32'h43);
    // R2 fill to 32 words, then one more is refused
    for (int i = 0; i < 33; i++) step(1, 32'h1000_0000 + i, 0, 0, 0, 0, 0, "R2");
    check(in_ready == 1'b0, "R2", {31'd0, in_ready}, 32'd0);
    // R3 drain in arrival order
    for (int i = 0; i < 32; i++) begin
      step(0, '0, 1, 0, 0, 0, 0, "R3");
      step(0, '0, 0, 1, 0, 0, 32, "R3");
      check(last_fld == 32'(8'(i)), "R3", last_fld, 32'(8'(i)));
    end
    // R8 load and read in same cycle
    step(1, 32'hA1B2_C3D4, 0, 0, 0, 0, 0, "R8");
    step(0, '0, 1, 1, 0, 0, 0, "R8");
    step(0, '0, 0, 1, 0, 0, 0, "R8");
    check(last_fld == 32'hD4, "R8", last_fld, 32'hD4);
    // R9 write in same cycle as a read: read uses old width 8
    step(0, '0, 0, 1, 1, 4, 4, "R9");
    check(last_fld == 32'hC3, "R9", last_fld, 32'hC3);
    step(0, '0, 0, 1, 0, 0, 0, "R9");
    check(last_fld == 32'hB, "R9", last_fld, 32'hB);
    // R9 length 0 means 32
    step(0, '0, 0, 0, 1, 0, 0, "R9");
    step(1, 32'hDEAD_BEEF, 1, 0, 0, 0, 0, "R9");
    step(0, '0, 1, 0, 0, 0, 0, "R9");
    step(0, '0, 0, 1, 0, 0, 0, "R9");
    check(last_fld == 32'hDEAD_BEEF, "R9", last_fld, 32'hDEAD_BEEF);
    step(0, '0, 0, 0, 1, 0, 8, "R9");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit cw = (r < 3);
      int cl = cw ? (($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : 8) : 0;
      step($urandom_range(0, 1), $urandom, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1), cw, $urandom_range(0, 31), cl, "R5");
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule